// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block carries out the double-precision shift step of an integer execution unit. A destination operand moves left or right by a count, and the bit positions it vacates are filled from a second source operand. Both operands are either 16 or 32 bits wide. The block returns the shifted value together with carry, overflow, sign, zero and parity flags, a write-enable, and a one-cycle completion pulse.

The count arrives as a byte. It can come from an instruction immediate or from a count register, and the block treats both the same way. Only its low five bits are used. The current flag values come in alongside the operands, so that flags the operation does not change can pass through untouched.

Every operation takes exactly three clock edges from the start strobe to the done pulse. Operand fetch, memory write-back and fault handling are the surrounding pipeline's job.

Top module: `funnel_shifter`

## Requirements
- R1: Only bits 4:0 of `count` are used, so adding any multiple of 32 to the count has no effect on any output.
- R2: When the 5-bit count is zero, `result` equals the destination (the low 16 bits, zero-extended, in 16-bit mode), `wr_en` stays low and all five flag outputs equal their `*_in` inputs.
- R3: A left shift (`dir_right`=0) returns the destination shifted left by the count, with its vacated low bits filled from the most significant bits of the source.
- R4: A right shift (`dir_right`=1) returns the destination shifted right by the count, with its vacated high bits filled from the least significant bits of the source.
- R5: In 16-bit mode with counts 17 to 31, a left shift returns bits 31:16 of the 32-bit value {dst, src} shifted left by the count, truncated to 32 bits. A right shift returns the low 16 bits of {src, dst} shifted right by the count.
- R6: For a nonzero count c and width W, `cf` is destination bit W-c on a left shift and destination bit c-1 on a right shift. It is 0 when c exceeds W.
- R7: For a nonzero count, `sf` is the result's bit W-1, `zf` is 1 exactly when the result is zero, and `pf` is 1 when bits 7:0 of the result hold an even number of ones.
- R8: For a count of 1, `of` is the result's sign bit XOR the destination's original sign bit. For any other nonzero count, `of` equals `of_in`.
- R9: `done` pulses high for one cycle exactly three rising edges after the edge that samples `start`. `wr_en` is high only together with `done`, and only for a nonzero count.
- R10: `wide`=1 selects 32-bit operation. With `wide`=0, only bits 15:0 of `dst` and `src` are used and bits 31:16 of `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the present inputs |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| dst | input | 32 | Destination operand |
| src | input | 32 | Fill-source operand |
| count | input | 8 | Shift count (immediate or count register) |
| cf_in | input | 1 | Current carry flag |
| of_in | input | 1 | Current overflow flag |
| sf_in | input | 1 | Current sign flag |
| zf_in | input | 1 | Current zero flag |
| pf_in | input | 1 | Current parity flag |
| result | output | 32 | Shifted value |
| wr_en | output | 1 | Result should be written back |
| cf | output | 1 | Carry flag out |
| of | output | 1 | Overflow flag out |
| sf | output | 1 | Sign flag out |
| zf | output | 1 | Zero flag out |
| pf | output | 1 | Parity flag out |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: a 32-bit datapath with 16-bit narrow mode and an 8-bit count. Because the count is only five bits, a complete sweep of every count from 0 to 31 is cheap. It runs in both directions and both widths, over several operand patterns, with the upper count bits varied. That covers the zero-count bypass, the single-bit overflow rule, and the 16-bit counts above 16 where the destination is fully shifted out. In 16-bit mode the upper operand bits are loaded with non-zero data, so any leak from them shows up in the result.

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int DW = 32,
  parameter int HW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_right,
  input  logic          wide,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  input  logic [CW-1:0] count,
  input  logic          cf_in,
  input  logic          of_in,
  input  logic          sf_in,
  input  logic          zf_in,
  input  logic          pf_in,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic          cf,
  output logic          of,
  output logic          sf,
  output logic          zf,
  output logic          pf,
  output logic          done
);
  localparam int SW  = $clog2(DW);
  localparam int LAT = 3;
  localparam int FW  = 6;

  logic [SW-1:0]   c;
  logic [SW:0]     wid;
  logic [DW-1:0]   dm, sm;
  logic [2*DW-1:0] lsh, rsh;
  logic [DW-1:0]   res_n;
  logic            cf_n, of_n, sf_n, zf_n, pf_n, dmsb;

  assign c   = count[SW-1:0];
  assign wid = wide ? (SW+1)'(DW) : (SW+1)'(HW);
  assign dm  = wide ? dst : {{(DW-HW){1'b0}}, dst[HW-1:0]};
  assign sm  = wide ? src : {{(DW-HW){1'b0}}, src[HW-1:0]};
  assign lsh = wide ? ({dm, sm} << c) : ({{DW{1'b0}}, dm[HW-1:0], sm[HW-1:0]} << c);
  assign rsh = wide ? ({sm, dm} >> c) : ({{DW{1'b0}}, sm[HW-1:0], dm[HW-1:0]} >> c);

  always_comb begin
    if (dir_right)
      res_n = wide ? rsh[DW-1:0] : {{(DW-HW){1'b0}}, rsh[HW-1:0]};
    else
      res_n = wide ? lsh[2*DW-1:DW] : {{(DW-HW){1'b0}}, lsh[2*HW-1:HW]};
    if (c == '0) res_n = dm;
  end

  always_comb begin
    cf_n = 1'b0;
    if ({1'b0, c} <= wid && c != '0) begin
      if (dir_right) cf_n = dm[SW'(c - 1'b1)];
      else           cf_n = dm[SW'(wid - {1'b0, c})];
    end
  end

  assign dmsb = wide ? dm[DW-1] : dm[HW-1];
  assign sf_n = wide ? res_n[DW-1] : res_n[HW-1];
  assign zf_n = (res_n == '0);
  assign pf_n = ~^res_n[7:0];
  assign of_n = (c == SW'(1)) ? (sf_n ^ dmsb) : of_in;

  logic [DW-1:0] res_q [LAT];
  logic [FW-1:0] flg_q [LAT];
  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) begin
        res_q[i] <= '0;
        flg_q[i] <= '0;
      end
    end else begin
      vld_q <= {vld_q[LAT-2:0], start};
      res_q[0] <= res_n;
      if (c == '0)
        flg_q[0] <= {1'b0, cf_in, of_in, sf_in, zf_in, pf_in};
      else
        flg_q[0] <= {1'b1, cf_n, of_n, sf_n, zf_n, pf_n};
      for (int i = 1; i < LAT; i++) begin
        res_q[i] <= res_q[i-1];
        flg_q[i] <= flg_q[i-1];
      end
    end
  end

  assign done   = vld_q[LAT-1];
  assign result = res_q[LAT-1];
  assign wr_en  = done & flg_q[LAT-1][5];
  assign cf     = flg_q[LAT-1][4];
  assign of     = flg_q[LAT-1][3];
  assign sf     = flg_q[LAT-1][2];
  assign zf     = flg_q[LAT-1][1];
  assign pf     = flg_q[LAT-1][0];
endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wide,
  input logic [31:0] dst,
  input logic [7:0]  count,
  input logic        cf_in,
  input logic        of_in,
  input logic [31:0] result,
  input logic        wr_en,
  input logic        cf,
  input logic        of,
  input logic        sf,
  input logic        zf,
  input logic        done
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 done);  // R9
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));  // R9
  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);  // R9
  AST_ZERO_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(count[4:0] == 5'd0, 3)) |-> (!wr_en && cf == $past(cf_in, 3)));  // R2
  AST_SIGN_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sf == ($past(wide, 3) ? result[31] : result[15])));  // R7
  AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (zf == (result == 32'd0)));  // R7
  AST_OF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(count[4:0] != 5'd1, 3)) |-> (of == $past(of_in, 3)));  // R8
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(wide, 3)) |-> (result[31:16] == 16'd0));  // R10
endmodule

bind funnel_shifter funnel_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .dst(dst),
  .count(count), .cf_in(cf_in), .of_in(of_in), .result(result),
  .wr_en(wr_en), .cf(cf), .of(of), .sf(sf), .zf(zf), .done(done)
);

// File: tb/tb_funnel_shifter.sv
`timescale 1ns/1ps
module tb_funnel_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_right = 1'b0, wide = 1'b0;
  logic [31:0] dst = '0, src = '0;
  logic [7:0] count = '0;
  logic cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0;
  logic [31:0] result;
  logic wr_en, cf, of, sf, zf, pf, done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  funnel_shifter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_right(dir_right), .wide(wide),
    .dst(dst), .src(src), .count(count), .cf_in(cf_in), .of_in(of_in),
    .sf_in(sf_in), .zf_in(zf_in), .pf_in(pf_in), .result(result), .wr_en(wr_en),
    .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit rt, input bit wd, input logic [31:0] d32,
                        input logic [31:0] s32, input logic [7:0] cnt, input logic [4:0] fin);
    int w, c, ones;
    longint unsigned m, d, s, v, er;
    bit ecf, eof, esf, ezf, epf, ewe;
    string rq;
    w = wd ? 32 : 16;
    m = (64'd1 << w) - 1;
    d = {32'd0, d32} & m;
    s = {32'd0, s32} & m;
    c = int'(cnt & 8'd31);
    if (c == 0) begin
      er = d; {ecf, eof, esf, ezf, epf} = fin; ewe = 0;
    end else begin
      if (rt) begin v = (s << w) | d; er = (v >> c) & m; ecf = (c <= w) ? d[c-1] : 1'b0; end
      else    begin v = (d << w) | s; er = ((v << c) >> w) & m; ecf = (c <= w) ? d[w-c] : 1'b0; end
      esf = er[w-1];
      ezf = (er == 0);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(er[i]);
      epf = (ones % 2 == 0);
      eof = (c == 1) ? (esf ^ d[w-1]) : fin[3];
      ewe = 1;
    end
    @(negedge clk);
    dir_right = rt; wide = wd; dst = d32; src = s32; count = cnt;
    {cf_in, of_in, sf_in, zf_in, pf_in} = fin;
    start = 1;
    @(negedge clk); start = 0;
    chk("R9", "done early", done, 0);
    @(negedge clk);
    @(negedge clk);
    rq = (c == 0) ? "R2" : (!wd && c > 16) ? "R5" : rt ? "R4" : "R3";
    chk("R9", "done", done, 1);
    chk(rq, "result", result, er);
    chk(c == 0 ? "R2" : "R9", "wr_en", wr_en, ewe);
    chk(c == 0 ? "R2" : "R6", "cf", cf, ecf);
    chk(c == 0 ? "R2" : "R8", "of", of, eof);
    chk(c == 0 ? "R2" : "R7", "sf", sf, esf);
    chk(c == 0 ? "R2" : "R7", "zf", zf, ezf);
    chk(c == 0 ? "R2" : "R7", "pf", pf, epf);
    if (!wd) chk("R10", "upper result", result[31:16], 0);
    if (cnt[7:5] != 0) chk("R1", "masked count result", result, er);
    @(negedge clk);
    chk("R9", "done pulse width", done, 0);
  endtask

  initial begin
    logic [31:0] dpat [6] = '{32'h8000_0001, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_8765, 32'hA5A5_5A5A};
    logic [31:0] spat [6] = '{32'h0000_0000, 32'h0F0F_F0F0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hCAFE_3C1F, 32'h5A5A_A5A5};
    repeat (3) @(negedge clk);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset wr_en", wr_en, 0);
    rst_n = 1;
    for (int p = 0; p < 6; p++)
      for (int wd = 0; wd < 2; wd++)
        for (int rt = 0; rt < 2; rt++)
          for (int c = 0; c < 32; c++)
            run_op(rt[0], wd[0], dpat[p], spat[p], 8'(c + 32 * ((p + c) % 8)), 5'((p * 7 + c) % 32));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule